// File: doc/BRIEF.md
# EEPROM Station Address Loader

This block fetches the station (MAC) address of a network controller from a serial configuration EEPROM and judges whether the contents can be trusted. It has no serial protocol logic of its own. It drives a simple request/response read port that some other block turns into serial EEPROM cycles. A load runs by itself once reset is released, and it runs again each time the start input is pulsed after a load has ended.

A load begins with one probe read of word 0 using narrow (6-bit) word addressing. An all-ones result means the device needs wide (8-bit) addressing, and every later read uses that mode. The block then reads the image words in ascending order and adds them modulo 2^16. It also collects the bytes of the first three words into the station address. The image is accepted only when the sum equals a fixed signature. If it does not, the block forces the address output to zero and raises a checksum error. If the read port reports a timeout, the block abandons the load and raises a separate timeout error.

Top module: `eeprom_mac_loader`

## Requirements
- R1: The first request of every load is for word 0 with `rd_wide` low (6-bit addressing). If that probe returns 0xFFFF, every later request of the load has `rd_wide` high; otherwise every later request has it low. `addr_wide` shows the detected width once the load ends (1 = 8-bit).
- R2: After the probe, words 0 to 63 are requested exactly once each, in ascending order, so that a complete load makes 65 requests.
- R3: The 64 words are added modulo 2^16. `csum_err` is 0 when the sum equals 0xBABA and 1 otherwise.
- R4: `station_addr` is built from words 0, 1 and 2. Bits [47:40] hold the low byte of word 0, bits [39:32] its high byte, bits [31:24] and [23:16] the low and high bytes of word 1, and bits [15:8] and [7:0] the low and high bytes of word 2.
- R5: `station_addr` reads all zeros whenever the checksum fails, whenever no load has completed, and while a load is running.
- R6: `addr_valid` rises in the cycle after the response to the word 63 request is accepted. `csum_err` takes its value in that same cycle.
- R7: A `start` pulse during a load has no effect: the load continues and still makes exactly 65 requests.
- R8: A `start` pulse after a load has ended clears `addr_valid`, `csum_err`, `timeout_err` and the address, then runs the full sequence again.
- R9: An `rd_timeout` pulse ends the load. It sets `timeout_err`, keeps `addr_valid` low and the address at zero, and no further request is made.
- R10: In reset all outputs are low and no request is made. A load starts without any `start` pulse after reset is released.
- R11: `rd_req` stays high with `rd_addr` and `rd_wide` unchanged until `rd_valid` or `rd_timeout` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that requests a new load |
| rd_req | output | 1 | Read request to the EEPROM port |
| rd_addr | output | 8 | Word address of the request |
| rd_wide | output | 1 | 1 = use 8-bit addressing, 0 = 6-bit |
| rd_valid | input | 1 | One-cycle pulse: read data present |
| rd_data | input | 16 | Read data word |
| rd_timeout | input | 1 | One-cycle pulse: the read failed |
| station_addr | output | 48 | Station address, zero unless valid and checksum good |
| addr_valid | output | 1 | A full load has completed |
| csum_err | output | 1 | The completed load failed the signature check |
| timeout_err | output | 1 | The load was ended by a read timeout |
| addr_wide | output | 1 | Detected addressing width (1 = 8-bit) |

## Verification
On every cycle, the assertions check the read handshake: a held request stays stable, the probe is for word 0 in narrow mode, and each accepted word advances the address by one. They also check that the width flag does not change during the word reads, that a nonzero address implies a good completed load, that a timeout leaves the outputs cleared, and that the valid flag rises only after a response. The sums, the byte order, the choice of width from the probe, and the exact count and order of requests depend on image contents and on the stimulus sequence, so only the bench scenarios can show them. The same holds for ignoring a start pulse during a load and for recovering after a timeout.

// File: rtl/eml_pkg.sv
// Package: shared types for the EEPROM station address loader.
// Assumes: 16-bit EEPROM words; nothing here depends on the image size.
package eml_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_READ  = 2'd2
    } eml_state_t;
endpackage

// File: rtl/eml_seq.sv
// Sequencer: issues the probe read and then the word reads.
// Detects the address width from the probe and raises per-word strobes.
// Assumes: the read port answers each held request with exactly one
// rd_valid or rd_timeout pulse.
module eml_seq
    import eml_pkg::*;
#(
    parameter int WORDS   = 64,
    parameter int DATA_W  = 16,
    parameter int WIDE_AW = 8,
    parameter int IDX_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rsp_valid_i,
    input  logic [DATA_W-1:0]  rsp_data_i,
    input  logic               rsp_timeout_i,
    output logic               rd_req_o,
    output logic [WIDE_AW-1:0] rd_addr_o,
    output logic               rd_wide_o,
    output logic               clr_o,
    output logic               word_we_o,
    output logic [IDX_W-1:0]   word_idx_o,
    output logic               last_o,
    output logic               abort_o
);
    localparam logic [DATA_W-1:0] BLANK    = {DATA_W{1'b1}};
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORDS - 1);

    eml_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             wide_q;
    logic             boot_q;
    logic             go;

    // Launch a load on the first idle cycle after reset or on a start pulse.
    assign go = (state_q == ST_IDLE) && (start_i || boot_q);

    // State, word index and detected width registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wide_q  <= 1'b0;
            boot_q  <= 1'b1;
        end else begin
            boot_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q <= ST_PROBE;
                        idx_q   <= '0;
                        wide_q  <= 1'b0;
                    end
                end
                ST_PROBE: begin
                    if (rsp_timeout_i) begin
                        state_q <= ST_IDLE;
                    end else if (rsp_valid_i) begin
                        wide_q  <= (rsp_data_i == BLANK);
                        idx_q   <= '0;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rsp_timeout_i) begin
                        state_q <= ST_IDLE;
                    end else if (rsp_valid_i) begin
                        if (idx_q == LAST_IDX) state_q <= ST_IDLE;
                        else                   idx_q   <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Read port drive and strobes for the accumulator.
    always_comb begin
        rd_req_o   = (state_q != ST_IDLE);
        rd_addr_o  = (state_q == ST_READ) ? WIDE_AW'(idx_q) : '0;
        rd_wide_o  = (state_q == ST_READ) ? wide_q : 1'b0;
        clr_o      = go;
        word_we_o  = (state_q == ST_READ) && rsp_valid_i && !rsp_timeout_i;
        word_idx_o = idx_q;
        last_o     = word_we_o && (idx_q == LAST_IDX);
        abort_o    = (state_q != ST_IDLE) && rsp_timeout_i;
    end

    assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rsp_valid_i && !rsp_timeout_i) |=>
            (rd_req_o && $stable(rd_addr_o) && $stable(rd_wide_o)))
        else $error("assert_req_held_R11");

    assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE) |-> (rd_addr_o == '0 && !rd_wide_o))
        else $error("assert_probe_narrow_R1");

    assert property (@(posedge clk) disable iff (!rst_n)
        (word_we_o && !last_o) |=> (rd_addr_o == $past(rd_addr_o) + 1'b1))
        else $error("assert_addr_ascending_R2");

    assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q) == ST_READ) |-> $stable(wide_q))
        else $error("assert_width_fixed_R1");
endmodule

// File: rtl/eml_accum.sv
// Accumulator: sums the image words, gathers the station address bytes
// and holds the completion and error flags.
// Assumes: strobes come from eml_seq; clr_i starts a fresh load.
module eml_accum #(
    parameter int               WORDS     = 64,
    parameter int               DATA_W    = 16,
    parameter int               MAC_WORDS = 3,
    parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA,
    parameter int               IDX_W     = $clog2(WORDS),
    parameter int               MAC_W     = MAC_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              word_we_i,
    input  logic [IDX_W-1:0]  word_idx_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              last_i,
    input  logic              abort_i,
    output logic [MAC_W-1:0]  mac_o,
    output logic              valid_o,
    output logic              csum_err_o,
    output logic              to_err_o
);
    localparam int HB = DATA_W / 2;

    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] sum_next;
    logic [MAC_W-1:0]  mac_q;

    // Running sum including the word being accepted this cycle.
    assign sum_next = sum_q + word_i;

    // Sum, address bytes and flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sum_q      <= '0;
            mac_q      <= '0;
            valid_o    <= 1'b0;
            csum_err_o <= 1'b0;
            to_err_o   <= 1'b0;
        end else begin
            if (word_we_i) begin
                sum_q <= sum_next;
                for (int w = 0; w < MAC_WORDS; w++) begin
                    if (word_idx_i == IDX_W'(w))
                        mac_q[(MAC_WORDS-1-w)*DATA_W +: DATA_W] <=
                            {word_i[HB-1:0], word_i[DATA_W-1:HB]};
                end
            end
            if (last_i) begin
                valid_o    <= 1'b1;
                csum_err_o <= (sum_next != SIGNATURE);
            end
            if (abort_i) to_err_o <= 1'b1;
        end
    end

    assign mac_o = mac_q;

    assert property (@(posedge clk) disable iff (!rst_n)
        csum_err_o |-> valid_o)
        else $error("assert_err_with_valid_R6");

    assert property (@(posedge clk) disable iff (!rst_n)
        to_err_o |-> !valid_o)
        else $error("assert_timeout_not_valid_R9");
endmodule

// File: rtl/eeprom_mac_loader.sv
// Top: EEPROM station address loader. Connects the sequencer to the
// accumulator and masks the address output unless the image checked good.
// Assumes: an external block converts the read port to serial EEPROM cycles.
module eeprom_mac_loader #(
    parameter int WORDS     = 64,
    parameter int DATA_W    = 16,
    parameter int WIDE_AW   = 8,
    parameter int MAC_WORDS = 3,
    parameter logic [15:0] SIGNATURE = 16'hBABA,
    parameter int IDX_W     = $clog2(WORDS),
    parameter int MAC_W     = MAC_WORDS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               rd_req,
    output logic [WIDE_AW-1:0] rd_addr,
    output logic               rd_wide,
    input  logic               rd_valid,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic               rd_timeout,
    output logic [MAC_W-1:0]   station_addr,
    output logic               addr_valid,
    output logic               csum_err,
    output logic               timeout_err,
    output logic               addr_wide
);
    logic             clr;
    logic             word_we;
    logic [IDX_W-1:0] word_idx;
    logic             last;
    logic             abort;
    logic [MAC_W-1:0] mac_raw;
    logic             wide_seen;

    eml_seq #(.WORDS(WORDS), .DATA_W(DATA_W), .WIDE_AW(WIDE_AW), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rsp_valid_i(rd_valid), .rsp_data_i(rd_data), .rsp_timeout_i(rd_timeout),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_wide_o(wide_seen),
        .clr_o(clr), .word_we_o(word_we), .word_idx_o(word_idx),
        .last_o(last), .abort_o(abort)
    );

    eml_accum #(.WORDS(WORDS), .DATA_W(DATA_W), .MAC_WORDS(MAC_WORDS),
                .SIGNATURE(DATA_W'(SIGNATURE)), .IDX_W(IDX_W), .MAC_W(MAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .word_we_i(word_we),
        .word_idx_i(word_idx), .word_i(rd_data), .last_i(last), .abort_i(abort),
        .mac_o(mac_raw), .valid_o(addr_valid), .csum_err_o(csum_err),
        .to_err_o(timeout_err)
    );

    // Detected-width register: follows the read-phase width, held after the load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) addr_wide <= 1'b0;
        else if (word_we)  addr_wide <= wide_seen;
    end

    // Address reaches the output only for a completed, checksum-clean load.
    assign rd_wide      = wide_seen;
    assign station_addr = (addr_valid && !csum_err) ? mac_raw : '0;

    assert property (@(posedge clk) disable iff (!rst_n)
        (station_addr != '0) |-> (addr_valid && !csum_err))
        else $error("assert_addr_masked_R5");

    assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(rd_valid))
        else $error("assert_valid_after_rsp_R6");

    assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (station_addr == '0 && !addr_valid))
        else $error("assert_timeout_clears_R9");
endmodule

// File: tb/tb_eeprom_mac_loader.sv
module tb_eeprom_mac_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic        rd_wide;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        rd_timeout = 1'b0;
    logic [47:0] station_addr;
    logic        addr_valid, csum_err, timeout_err, addr_wide;

    always #10 clk = ~clk;

    eeprom_mac_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_wide(rd_wide),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_timeout(rd_timeout),
        .station_addr(station_addr), .addr_valid(addr_valid),
        .csum_err(csum_err), .timeout_err(timeout_err), .addr_wide(addr_wide)
    );

    int          checks = 0;
    int          errors = 0;
    logic [15:0] mem [0:63];
    logic [7:0]  log_addr [0:255];
    logic        log_wide [0:255];
    int          nreq = 0;
    int          to_at = -1;
    int          lat = 1;

    // Read port model: logs each request, answers after lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                if (nreq < 256) begin
                    log_addr[nreq] = rd_addr;
                    log_wide[nreq] = rd_wide;
                end
                repeat (lat) @(negedge clk);
                if (nreq == to_at) rd_timeout = 1'b1;
                else begin
                    rd_valid = 1'b1;
                    rd_data  = mem[rd_addr[5:0]];
                end
                nreq++;
                @(negedge clk);
                rd_valid   = 1'b0;
                rd_timeout = 1'b0;
            end
        end
    end

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic build_image(input logic [15:0] seed, input logic [15:0] first,
                               input bit good);
        logic [15:0] s = '0;
        for (int i = 0; i < 63; i++) begin
            mem[i] = 16'(i * 16'h1357) ^ seed;
            if (i == 0) mem[i] = first;
            s = s + mem[i];
        end
        mem[63] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
    endtask

    function automatic logic [47:0] exp_mac();
        return {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8],
                mem[2][7:0], mem[2][15:8]};
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!addr_valid && !timeout_err && n < 3000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic check_sequence(input string rq, input logic wexp);
        int bad = 0;
        chk(rq, "request count", 64'(nreq), 64'd65);
        if (log_addr[0] !== 8'd0 || log_wide[0] !== 1'b0) bad++;
        for (int k = 1; k < 65; k++)
            if (log_addr[k] !== 8'(k - 1) || log_wide[k] !== wexp) bad++;
        chk(rq, "probe/order/width mismatches", 64'(bad), 64'd0);
    endtask

    task automatic t_reset_and_boot();
        build_image(16'h2468, 16'h1100, 1'b1);
        nreq = 0;
        repeat (3) @(negedge clk);
        chk("R10", "valid in reset", 64'(addr_valid), 64'd0);
        chk("R10", "addr in reset", 64'(station_addr), 64'd0);
        chk("R10", "req in reset", 64'(rd_req), 64'd0);
        rst_n = 1'b1;
        wait_end();
        chk("R10", "auto load valid", 64'(addr_valid), 64'd1);
        check_sequence("R2", 1'b0);
        chk("R3", "csum_err good image", 64'(csum_err), 64'd0);
        chk("R4", "address bytes", 64'(station_addr), 64'(exp_mac()));
        chk("R1", "narrow width", 64'(addr_wide), 64'd0);
    endtask

    task automatic t_wide();
        build_image(16'h5A5A, 16'hFFFF, 1'b1);
        nreq = 0;
        pulse_start();
        wait_end();
        check_sequence("R1", 1'b1);
        chk("R1", "wide width", 64'(addr_wide), 64'd1);
        chk("R3", "csum_err wide image", 64'(csum_err), 64'd0);
        chk("R4", "wide address bytes", 64'(station_addr), 64'(exp_mac()));
    endtask

    task automatic t_bad_sum();
        build_image(16'h0F0F, 16'h3412, 1'b0);
        nreq = 0;
        pulse_start();
        wait_end();
        chk("R6", "valid on bad image", 64'(addr_valid), 64'd1);
        chk("R3", "csum_err bad image", 64'(csum_err), 64'd1);
        chk("R5", "address zeroed", 64'(station_addr), 64'd0);
    endtask

    task automatic t_busy_start();
        build_image(16'h7E01, 16'hABCD, 1'b1);
        nreq = 0;
        pulse_start();
        while (nreq < 20) @(negedge clk);
        pulse_start();
        wait_end();
        chk("R7", "requests with start mid-load", 64'(nreq), 64'd65);
        chk("R7", "address after ignored start", 64'(station_addr), 64'(exp_mac()));
    endtask

    task automatic t_restart_clears();
        pulse_start();
        chk("R8", "valid cleared on restart", 64'(addr_valid), 64'd0);
        chk("R5", "address zero while loading", 64'(station_addr), 64'd0);
        wait_end();
    endtask

    task automatic t_timeout();
        build_image(16'h1234, 16'h0102, 1'b1);
        nreq = 0;
        to_at = 30;
        pulse_start();
        wait_end();
        repeat (10) @(negedge clk);
        chk("R9", "timeout_err", 64'(timeout_err), 64'd1);
        chk("R9", "valid after timeout", 64'(addr_valid), 64'd0);
        chk("R9", "address after timeout", 64'(station_addr), 64'd0);
        chk("R9", "no requests after timeout", 64'(nreq), 64'd31);
        to_at = -1;
        nreq = 0;
        lat = 3;
        pulse_start();
        chk("R8", "timeout_err cleared", 64'(timeout_err), 64'd0);
        wait_end();
        check_sequence("R8", 1'b0);
        chk("R8", "address after rerun", 64'(station_addr), 64'(exp_mac()));
        lat = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_and_boot();
        t_wide();
        t_bad_sum();
        t_busy_start();
        t_restart_clears();
        t_timeout();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule